// File: doc/BRIEF.md
# Circular Windowed Register File

This block is a register file in which each procedure sees 32 logical registers, while the storage behind them is a single shared pool of 74 physical words. Ten of the logical numbers reach global words that look the same from every procedure. The other 22 reach a window that a current window pointer selects. Each window has ten private words and two groups of six parameter words. The group a window uses for outgoing arguments is the same storage that the next window uses for incoming arguments, so a caller hands over arguments and collects results without copying anything. The windows form a ring: the outgoing group of the last window is the incoming group of the first.

The file has two combinational read ports and one write port, all addressed by 5-bit logical numbers. Writes land on the clock edge. A call input moves the pointer forward one window and a return input moves it back one. The block counts how many windows hold live frames. When a call would wrap onto a window whose frame is still live, it reports an overflow pulse. When a return goes past the oldest resident frame, it reports an underflow pulse. Saving and restoring windows in memory is left to the surrounding logic. The pointer still moves in both of those cases.

Top module: `rwin_file`

## Requirements
- R1: After reset the window pointer is 0, both flags are low, and every logical register reads zero.
- R2: Logical numbers 0 to 9 reach global words 0 to 9, the same words whatever the window pointer is.
- R3: With window pointer p, logical number n (n ≥ 10) reaches physical word 10 + ((16·p + n − 10) mod 64). As a result, logical 26 to 31 of window p are the same words as logical 10 to 15 of window p+1.
- R4: The outgoing words of window 3 (logical 26 to 31) wrap around and are the incoming words of window 0 (logical 10 to 15).
- R5: The private words of each window (logical 16 to 25) are not visible from any other window.
- R6: A write takes effect at the clock edge and reads are combinational. A read of the word being written in that cycle returns the old value.
- R7: A call alone sets the pointer to (p+1) mod 4 and a return alone sets it to (p−1) mod 4, visible after the edge.
- R8: When call and return are asserted together, the pointer does not change and no flag is raised.
- R9: A write in the same cycle as a call or a return is translated with the window pointer from before the edge.
- R10: The live-frame count starts at 1. A call while 3 frames are live raises the overflow flag for the cycle after the edge, and the pointer still advances. Otherwise a call adds a live frame.
- R11: A return while 1 frame is live raises the underflow flag for the cycle after the edge, and the pointer still moves back. Otherwise a return removes a live frame.
- R12: Each flag is a pulse that lasts one cycle, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Advance to the next window |
| ret_i | input | 1 | Go back to the previous window |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register to write |
| wr_data | input | 32 | Write data |
| ra_addr | input | 5 | Logical register for read port A |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 5 | Logical register for read port B |
| rb_data | output | 32 | Read port B data |
| cwp_o | output | 2 | Current window pointer |
| ovf_o | output | 1 | Window overflow pulse |
| unf_o | output | 1 | Window underflow pulse |

## Verification
Two things can happen in the same cycle: a register write and a pointer move. The bench writes logical 26 while it pulses call. After the edge it expects the value under logical 10 of the new window and not under logical 26, which shows the write used the pointer from before the call. It also reads a register in the cycle that register is being written and expects the old contents before the edge and the new contents after it. Call and return asserted together are driven as well, and the bench expects the pointer to stay put with both flags quiet.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

   // Pointer request decoded from the call/return pair
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_CALL = 2'b01,
      OP_RET  = 2'b10,
      OP_BOTH = 2'b11
   } win_op_e;

   function automatic win_op_e decode_op(input logic call, input logic ret);
      return win_op_e'({ret, call});
   endfunction

endpackage

// File: rtl/rwin_xlate.sv
// Logical-to-physical register number translation for one port.
module rwin_xlate #(
   parameter int NGLOB  = 10,
   parameter int NLOCAL = 10,
   parameter int NSHARE = 6,
   parameter int NWIN   = 4,
   parameter int LREG_W = 5,
   parameter int PHYS_W = 7,
   parameter int CWP_W  = 2
) (
   input  logic [CWP_W-1:0]  cwp,
   input  logic [LREG_W-1:0] lreg,
   output logic [PHYS_W-1:0] phys
);
   localparam int STRIDE = NLOCAL + NSHARE;
   localparam int POOL   = STRIDE * NWIN;

   int unsigned off;

   always_comb begin
      off  = 0;
      phys = '0;
      if (int'(lreg) < NGLOB) begin
         phys = PHYS_W'(lreg);
      end else begin
         off = int'(cwp) * STRIDE + int'(lreg) - NGLOB;
         // The offset is always below 2*POOL, so a single subtraction wraps it.
         if (off >= POOL) off = off - POOL;
         phys = PHYS_W'(NGLOB + off);
      end
   end
endmodule

// File: rtl/rwin_ptr.sv
// Window pointer, live-frame count and overflow/underflow pulses.
module rwin_ptr
   import rwin_pkg::*;
#(
   parameter int NWIN  = 4,
   parameter int CWP_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             call_i,
   input  logic             ret_i,
   output logic [CWP_W-1:0] cwp_o,
   output logic             ovf_o,
   output logic             unf_o
);
   localparam int LIVE_W = $clog2(NWIN) + 1;
   localparam logic [CWP_W-1:0]  LAST     = CWP_W'(NWIN - 1);
   localparam logic [LIVE_W-1:0] LIVE_MAX = LIVE_W'(NWIN - 1);
   localparam logic [LIVE_W-1:0] LIVE_MIN = LIVE_W'(1);

   win_op_e           op;
   logic [CWP_W-1:0]  cwp_q, cwp_inc, cwp_dec;
   logic [LIVE_W-1:0] live_q;
   logic              ovf_q, unf_q;

   assign op = decode_op(call_i, ret_i);

   // Wrap arithmetic: free-running when the ring size is a power of two
   if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      assign cwp_inc = cwp_q + 1'b1;
      assign cwp_dec = cwp_q - 1'b1;
   end else begin : g_cmp
      assign cwp_inc = (cwp_q == LAST) ? '0 : cwp_q + 1'b1;
      assign cwp_dec = (cwp_q == '0) ? LAST : cwp_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp_q  <= '0;
         live_q <= LIVE_MIN;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
      end else begin
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
         case (op)
            OP_CALL: begin
               cwp_q <= cwp_inc;
               if (live_q == LIVE_MAX) ovf_q <= 1'b1;
               else                    live_q <= live_q + 1'b1;
            end
            OP_RET: begin
               cwp_q <= cwp_dec;
               if (live_q == LIVE_MIN) unf_q <= 1'b1;
               else                    live_q <= live_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign cwp_o = cwp_q;
   assign ovf_o = ovf_q;
   assign unf_o = unf_q;

   p_call_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ret_i) |=> cwp_q == (($past(cwp_q) == LAST) ? '0 : $past(cwp_q) + 1'b1));
   p_ret_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i) |=> cwp_q == (($past(cwp_q) == '0) ? LAST : $past(cwp_q) - 1'b1));
   p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && ret_i) |=> ($stable(cwp_q) && !ovf_q && !unf_q));
   p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> $past(call_i && !ret_i));
   p_unf_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      unf_q |-> $past(ret_i && !call_i));
   p_flag_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_q && unf_q));
   p_live_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q >= LIVE_MIN) && (live_q <= LIVE_MAX));
endmodule

// File: rtl/rwin_store.sv
// Physical word pool: one write port and NRD combinational read ports.
module rwin_store #(
   parameter int DATA_W = 32,
   parameter int PHYS   = 74,
   parameter int PHYS_W = 7,
   parameter int NRD    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [PHYS_W-1:0]           wr_idx,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic [NRD-1:0][PHYS_W-1:0]  rd_idx,
   output logic [NRD-1:0][DATA_W-1:0]  rd_data
);
   logic [DATA_W-1:0] mem [PHYS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PHYS; i++) mem[i] <= '0;
      end else if (wr_en && int'(wr_idx) < PHYS) begin
         mem[wr_idx] <= wr_data;
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_data[r] = (int'(rd_idx[r]) < PHYS) ? mem[rd_idx[r]] : '0;
   end

   p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/rwin_file.sv
module rwin_file
   import rwin_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LREG_W = 5,
   parameter int NGLOB  = 10,
   parameter int NLOCAL = 10,
   parameter int NSHARE = 6,
   parameter int NWIN   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       call_i,
   input  logic                       ret_i,
   input  logic                       wr_en,
   input  logic [LREG_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [LREG_W-1:0]          ra_addr,
   output logic [DATA_W-1:0]          ra_data,
   input  logic [LREG_W-1:0]          rb_addr,
   output logic [DATA_W-1:0]          rb_data,
   output logic [$clog2(NWIN)-1:0]    cwp_o,
   output logic                       ovf_o,
   output logic                       unf_o
);
   localparam int PHYS   = (NLOCAL + NSHARE) * NWIN + NGLOB;
   localparam int PHYS_W = $clog2(PHYS);
   localparam int CWP_W  = $clog2(NWIN);
   localparam int NPORT  = 3;   // two reads and one write

   if (NGLOB + NLOCAL + 2 * NSHARE != 2 ** LREG_W) begin : g_bad_view
      $error("window view must fill the logical register space");
   end
   if (NWIN < 2) begin : g_bad_ring
      $error("at least two windows are needed");
   end

   logic [CWP_W-1:0]                cwp;
   logic [NPORT-1:0][LREG_W-1:0]    lreg;
   logic [NPORT-1:0][PHYS_W-1:0]    preg;
   logic [1:0][DATA_W-1:0]          rdat;

   assign lreg[0] = ra_addr;
   assign lreg[1] = rb_addr;
   assign lreg[2] = wr_addr;

   for (genvar p = 0; p < NPORT; p++) begin : g_xl
      rwin_xlate #(
         .NGLOB(NGLOB), .NLOCAL(NLOCAL), .NSHARE(NSHARE), .NWIN(NWIN),
         .LREG_W(LREG_W), .PHYS_W(PHYS_W), .CWP_W(CWP_W)
      ) u_xl (
         .cwp  (cwp),
         .lreg (lreg[p]),
         .phys (preg[p])
      );
   end

   rwin_ptr #(.NWIN(NWIN), .CWP_W(CWP_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .call_i (call_i),
      .ret_i  (ret_i),
      .cwp_o  (cwp),
      .ovf_o  (ovf_o),
      .unf_o  (unf_o)
   );

   rwin_store #(.DATA_W(DATA_W), .PHYS(PHYS), .PHYS_W(PHYS_W), .NRD(2)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (preg[2]),
      .wr_data (wr_data),
      .rd_idx  (preg[1:0]),
      .rd_data (rdat)
   );

   assign ra_data = rdat[0];
   assign rb_data = rdat[1];
   assign cwp_o   = cwp;

   p_phys_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(preg[0]) < PHYS) && (int'(preg[1]) < PHYS) && (int'(preg[2]) < PHYS));
   p_glob_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ra_addr) < NGLOB) |-> (preg[0] == PHYS_W'(ra_addr)));
endmodule

// File: tb/rwin_file_test.sv
module rwin_file_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_i = 1'b0, ret_i = 1'b0, wr_en = 1'b0;
   logic [4:0]  wr_addr = '0, ra_addr = '0, rb_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] ra_data, rb_data;
   logic [1:0]  cwp_o;
   logic        ovf_o, unf_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;   // 125 MHz

   rwin_file uut (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
      .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; call_i = 0; ret_i = 0; wr_en = 0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      step();
      wr_en = 0;
   endtask

   task automatic peek(input logic [4:0] a, output logic [31:0] d);
      ra_addr = a; #1; d = ra_data;
   endtask

   task automatic do_call();
      call_i = 1; step(); call_i = 0;
   endtask

   task automatic do_ret();
      ret_i = 1; step(); ret_i = 0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      bit all_zero = 1;
      do_reset();
      check("R1 cwp", {30'd0, cwp_o}, 32'd0);
      check("R1 flags", {30'd0, ovf_o, unf_o}, 32'd0);
      for (int i = 0; i < 32; i++) begin
         peek(5'(i), v);
         if (v !== 32'd0) all_zero = 0;
      end
      check("R1 regs zero", {31'd0, all_zero}, 32'd1);
   endtask

   task automatic t_globals();
      logic [31:0] v;
      do_reset();
      write_reg(5'd3, 32'hA5A5_0003);
      do_call();
      peek(5'd3, v);
      check("R2 global from window 1", v, 32'hA5A5_0003);
      rb_addr = 5'd9; #1;
      check("R2 global 9 untouched", rb_data, 32'd0);
      do_ret();
   endtask

   task automatic t_share();
      logic [31:0] v;
      do_reset();
      for (int i = 0; i < 6; i++) write_reg(5'(26 + i), 32'h1000 + 32'(i));
      do_call();
      check("R7 call step", {30'd0, cwp_o}, 32'd1);
      check("R10 no ovf on first call", {31'd0, ovf_o}, 32'd0);
      for (int i = 0; i < 6; i++) begin
         peek(5'(10 + i), v);
         check("R3 caller out = callee in", v, 32'h1000 + 32'(i));
      end
      write_reg(5'd12, 32'hBEEF);       // callee returns a result
      do_ret();
      check("R7 return step", {30'd0, cwp_o}, 32'd0);
      check("R11 no unf on matched return", {31'd0, unf_o}, 32'd0);
      peek(5'd28, v);
      check("R3 result seen by caller", v, 32'hBEEF);
   endtask

   task automatic t_locals();
      logic [31:0] v;
      do_reset();
      write_reg(5'd16, 32'h0000_1616);
      write_reg(5'd25, 32'h0000_2525);
      do_call();
      peek(5'd16, v);
      check("R5 local hidden in window 1", v, 32'd0);
      peek(5'd25, v);
      check("R5 local hidden in window 1 (25)", v, 32'd0);
      do_ret();
      peek(5'd16, v);
      check("R5 local kept in window 0", v, 32'h0000_1616);
   endtask

   task automatic t_read_during_write();
      do_reset();
      write_reg(5'd20, 32'h1111_1111);
      ra_addr = 5'd20;
      wr_en = 1; wr_addr = 5'd20; wr_data = 32'h2222_2222;
      #1;
      check("R6 old value before edge", ra_data, 32'h1111_1111);
      step();
      wr_en = 0; #1;
      check("R6 new value after edge", ra_data, 32'h2222_2222);
   endtask

   task automatic t_overflow_wrap();
      logic [31:0] v;
      do_reset();
      do_call();
      do_call();
      check("R10 no ovf at 3 live", {31'd0, ovf_o}, 32'd0);
      do_call();
      check("R10 ovf pulse", {31'd0, ovf_o}, 32'd1);
      check("R10 pointer still advances", {30'd0, cwp_o}, 32'd3);
      check("R12 no unf with ovf", {31'd0, unf_o}, 32'd0);
      write_reg(5'd26, 32'hC0DE_0026);
      check("R12 ovf lasts one cycle", {31'd0, ovf_o}, 32'd0);
      write_reg(5'd31, 32'hC0DE_0031);
      do_call();
      check("R7 wrap to window 0", {30'd0, cwp_o}, 32'd0);
      peek(5'd10, v);
      check("R4 window 3 out is window 0 in", v, 32'hC0DE_0026);
      peek(5'd15, v);
      check("R4 wrap last shared word", v, 32'hC0DE_0031);
   endtask

   task automatic t_underflow();
      do_reset();
      do_ret();
      check("R11 unf pulse", {31'd0, unf_o}, 32'd1);
      check("R11 pointer still moves back", {30'd0, cwp_o}, 32'd3);
      check("R12 no ovf with unf", {31'd0, ovf_o}, 32'd0);
      step();
      check("R12 unf lasts one cycle", {31'd0, unf_o}, 32'd0);
      do_call();
      check("R11 live stays 1 then call ok", {31'd0, ovf_o}, 32'd0);
      check("R7 call wraps 3 to 0", {30'd0, cwp_o}, 32'd0);
   endtask

   task automatic t_both();
      do_reset();
      do_call();
      call_i = 1; ret_i = 1; step(); call_i = 0; ret_i = 0;
      check("R8 pointer held", {30'd0, cwp_o}, 32'd1);
      check("R8 no flags", {30'd0, ovf_o, unf_o}, 32'd0);
   endtask

   task automatic t_call_with_write();
      logic [31:0] v;
      do_reset();
      call_i = 1; wr_en = 1; wr_addr = 5'd26; wr_data = 32'h5EED_0026;
      step();
      call_i = 0; wr_en = 0;
      check("R9 pointer moved", {30'd0, cwp_o}, 32'd1);
      peek(5'd10, v);
      check("R9 write used old window", v, 32'h5EED_0026);
      peek(5'd26, v);
      check("R9 new window out untouched", v, 32'd0);
      ret_i = 1; wr_en = 1; wr_addr = 5'd16; wr_data = 32'h7777_0016;
      step();
      ret_i = 0; wr_en = 0;
      peek(5'd16, v);
      check("R9 return write left window 0 local", v, 32'd0);
      do_call();
      peek(5'd16, v);
      check("R9 return write hit window 1 local", v, 32'h7777_0016);
   endtask

   initial begin
      t_reset();
      t_globals();
      t_share();
      t_locals();
      t_read_during_write();
      t_overflow_wrap();
      t_underflow();
      t_both();
      t_call_with_write();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule